// File: doc/BRIEF.md
# Address-Space-Tagged Instruction Cache

A direct-mapped, physically addressed instruction cache for a fetch unit. Each line holds one 32-byte block of instructions, the upper address bits as a tag, a 6-bit address-space number, a global flag and an 8-bit branch history field. A fetch lookup presents a physical address together with the current address-space number. One cycle later the cache answers with a hit indication, the whole line and its stored history bits.

A hit needs three things: the line is valid, its tag equals the address tag, and the line either carries the global flag or holds the same address-space number as the lookup. Refills arrive on a fill port. A fill writes the line and its global flag, stamps the line with the current address-space number, and clears its history to zero. A separate history port rewrites the history of a line, but only when the addressed line is resident. A flush input drops every line at once, for use when address-space numbers are handed out again.

The cache keeps no coherence with memory and has no invalidate input. A line leaves only through refill of its index, flush, or reset.

Top module: `icache_asn`

## Requirements
- R1: After reset every line is invalid, so every lookup misses (`respHit` = 0), and `respHit` is never 1 while `respValid` is 0.
- R2: After a fill, a lookup of the same tag and index answers a hit. The response carries the filled line data and a history of zero, provided the lookup's `curAsn` equals the `curAsn` present at the fill.
- R3: A line filled with `fillGlobal` = 0 misses when the lookup's `curAsn` differs from the stored number. Any line misses when the address tag differs from the stored tag.
- R4: A line filled with `fillGlobal` = 1 hits under any `curAsn`.
- R5: A history write whose address matches a resident line (valid, same index, same tag) replaces that line's history, and later hits return the new value.
- R6: A history write whose tag does not match the resident line at that index leaves the stored history unchanged.
- R7: Refilling an index with a new tag evicts the old line, so the old tag misses. The new line's history reads zero.
- R8: A flush invalidates every line at the clock edge where it is sampled. A fill in the same cycle is discarded, so every later lookup misses until a refill.
- R9: A lookup in the same cycle as a fill to the same line sees the contents from before that edge, so it misses. A lookup in the next cycle hits.
- R10: When a fill and a history write target the same index in the same cycle, the fill wins and the history reads zero.
- R11: `respValid` is 1 exactly in the cycle after `lookupValid` was sampled 1, and 0 otherwise. Responses come back in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines |
| curAsn | input | ASN_W | Current address-space number (lookup compare, fill stamp) |
| lookupValid | input | 1 | Lookup request |
| lookupAddr | input | PADDR_W | Physical lookup address |
| respValid | output | 1 | Response valid, one cycle after request |
| respHit | output | 1 | Lookup hit |
| respData | output | LINE_BYTES*8 | Line data (meaningful on hit) |
| respHist | output | HIST_W | Stored branch history (meaningful on hit) |
| fillValid | input | 1 | Refill request |
| fillAddr | input | PADDR_W | Physical address of the refilled line |
| fillGlobal | input | 1 | Global flag written with the line |
| fillData | input | LINE_BYTES*8 | Refill data |
| histValid | input | 1 | History write request |
| histAddr | input | PADDR_W | Physical address of the line to update |
| histData | input | HIST_W | New history value |

## Verification
The bench builds the cache with a 1 KB capacity, giving 32 lines, and a 20-bit physical address, giving a 10-bit tag. With few lines, several tags can be aimed at one index, so eviction, non-resident history writes and fill/history collisions are all reachable in a handful of cycles. Same-cycle fill/lookup and fill/flush cases are driven on purpose. The 32-byte line width stays at its default, so the full-line data compare covers the real datapath width.

// File: rtl/icache_asn_pkg.sv
package icache_asn_pkg;
  typedef struct packed {
    logic clearAll;   // drop every valid bit
    logic writeLine;  // install the fill line
    logic writeHist;  // update history of a resident line
    logic capture;    // register a lookup response
  } icStrobe_t;
endpackage

// File: rtl/icache_asn_ctrl.sv
module icache_asn_ctrl
  import icache_asn_pkg::*;
(
  input  logic      flush,
  input  logic      fillValid,
  input  logic      histValid,
  input  logic      lookupValid,
  input  logic      histResident,
  input  logic      histFillSame,
  output icStrobe_t strobe
);
  always_comb begin
    strobe.clearAll  = flush;
    strobe.writeLine = fillValid & ~flush;
    // fill to the same index takes precedence over a history write
    strobe.writeHist = histValid & histResident & ~flush & ~(fillValid & histFillSame);
    strobe.capture   = lookupValid;
  end
endmodule

// File: rtl/icache_asn_dp.sv
module icache_asn_dp
  import icache_asn_pkg::*;
#(
  parameter int PADDR_W     = 34,
  parameter int CACHE_BYTES = 8192,
  parameter int LINE_BYTES  = 32,
  parameter int ASN_W       = 6,
  parameter int HIST_W      = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  icStrobe_t               strobe,
  input  logic [PADDR_W-1:0]      lookupAddr,
  input  logic [ASN_W-1:0]        curAsn,
  input  logic [PADDR_W-1:0]      fillAddr,
  input  logic                    fillGlobal,
  input  logic [LINE_BYTES*8-1:0] fillData,
  input  logic [PADDR_W-1:0]      histAddr,
  input  logic [HIST_W-1:0]       histData,
  output logic                    histResident,
  output logic                    histFillSame,
  output logic                    respValid,
  output logic                    respHit,
  output logic [LINE_BYTES*8-1:0] respData,
  output logic [HIST_W-1:0]       respHist
);
  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam int NUM_LINES = CACHE_BYTES / LINE_BYTES;
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int TAG_W     = PADDR_W - IDX_W - OFF_W;

  logic [NUM_LINES-1:0] validQ;
  logic [TAG_W-1:0]     tagMem  [NUM_LINES];
  logic [ASN_W-1:0]     asnMem  [NUM_LINES];
  logic                 globMem [NUM_LINES];
  logic [HIST_W-1:0]    histMem [NUM_LINES];
  logic [LINE_BITS-1:0] dataMem [NUM_LINES];

  logic [IDX_W-1:0] lkIdx, flIdx, hsIdx;
  logic [TAG_W-1:0] lkTag, flTag, hsTag;
  logic             lkHit;

  assign lkIdx = lookupAddr[OFF_W +: IDX_W];
  assign lkTag = lookupAddr[PADDR_W-1 -: TAG_W];
  assign flIdx = fillAddr[OFF_W +: IDX_W];
  assign flTag = fillAddr[PADDR_W-1 -: TAG_W];
  assign hsIdx = histAddr[OFF_W +: IDX_W];
  assign hsTag = histAddr[PADDR_W-1 -: TAG_W];

  assign lkHit = validQ[lkIdx] && (tagMem[lkIdx] == lkTag) &&
                 (globMem[lkIdx] || (asnMem[lkIdx] == curAsn));
  assign histResident = validQ[hsIdx] && (tagMem[hsIdx] == hsTag);
  assign histFillSame = (hsIdx == flIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strobe.clearAll) begin
      validQ <= '0;
    end else if (strobe.writeLine) begin
      validQ[flIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.writeLine) begin
      tagMem[flIdx]  <= flTag;
      asnMem[flIdx]  <= curAsn;
      globMem[flIdx] <= fillGlobal;
      dataMem[flIdx] <= fillData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.writeLine) begin
      histMem[flIdx] <= '0;
    end else if (strobe.writeHist) begin
      histMem[hsIdx] <= histData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
    end else begin
      respValid <= strobe.capture;
      respHit   <= strobe.capture & lkHit;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      respData <= dataMem[lkIdx];
      respHist <= histMem[lkIdx];
    end
  end
endmodule

// File: rtl/icache_asn.sv
module icache_asn
  import icache_asn_pkg::*;
#(
  parameter int PADDR_W     = 34,
  parameter int CACHE_BYTES = 8192,
  parameter int LINE_BYTES  = 32,
  parameter int ASN_W       = 6,
  parameter int HIST_W      = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    flush,
  input  logic [ASN_W-1:0]        curAsn,
  input  logic                    lookupValid,
  input  logic [PADDR_W-1:0]      lookupAddr,
  output logic                    respValid,
  output logic                    respHit,
  output logic [LINE_BYTES*8-1:0] respData,
  output logic [HIST_W-1:0]       respHist,
  input  logic                    fillValid,
  input  logic [PADDR_W-1:0]      fillAddr,
  input  logic                    fillGlobal,
  input  logic [LINE_BYTES*8-1:0] fillData,
  input  logic                    histValid,
  input  logic [PADDR_W-1:0]      histAddr,
  input  logic [HIST_W-1:0]       histData
);
  icStrobe_t strobe;
  logic      histResident;
  logic      histFillSame;

  icache_asn_ctrl uCtrl (
    .flush       (flush),
    .fillValid   (fillValid),
    .histValid   (histValid),
    .lookupValid (lookupValid),
    .histResident(histResident),
    .histFillSame(histFillSame),
    .strobe      (strobe)
  );

  icache_asn_dp #(
    .PADDR_W    (PADDR_W),
    .CACHE_BYTES(CACHE_BYTES),
    .LINE_BYTES (LINE_BYTES),
    .ASN_W      (ASN_W),
    .HIST_W     (HIST_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .lookupAddr  (lookupAddr),
    .curAsn      (curAsn),
    .fillAddr    (fillAddr),
    .fillGlobal  (fillGlobal),
    .fillData    (fillData),
    .histAddr    (histAddr),
    .histData    (histData),
    .histResident(histResident),
    .histFillSame(histFillSame),
    .respValid   (respValid),
    .respHit     (respHit),
    .respData    (respData),
    .respHist    (respHist)
  );
endmodule

// File: rtl/icache_asn_chk.sv
module icache_asn_chk #(
  parameter int PADDR_W    = 34,
  parameter int LINE_BYTES = 32,
  parameter int ASN_W      = 6,
  parameter int HIST_W     = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    flush,
  input logic [ASN_W-1:0]        curAsn,
  input logic                    lookupValid,
  input logic [PADDR_W-1:0]      lookupAddr,
  input logic                    respValid,
  input logic                    respHit,
  input logic [LINE_BYTES*8-1:0] respData,
  input logic [HIST_W-1:0]       respHist,
  input logic                    fillValid,
  input logic [PADDR_W-1:0]      fillAddr,
  input logic                    fillGlobal,
  input logic [LINE_BYTES*8-1:0] fillData
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  assert_hit_implies_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respValid);

  assert_resp_follows_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  assert_no_spurious_resp_R11: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);

  assert_miss_after_flush_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(flush) && lookupValid) |=> !respHit);

  assert_fill_then_hit_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(fillValid) && !$past(flush) && lookupValid &&
     ((lookupAddr >> OFF_W) == ($past(fillAddr) >> OFF_W)) &&
     ($past(fillGlobal) || (curAsn == $past(curAsn))))
    |=> (respHit && (respData == $past(fillData, 2))));

  assert_fill_clears_hist_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(fillValid) && !$past(flush) && lookupValid &&
     ((lookupAddr >> OFF_W) == ($past(fillAddr) >> OFF_W)) &&
     ($past(fillGlobal) || (curAsn == $past(curAsn))))
    |=> (respHist == '0));
endmodule

bind icache_asn icache_asn_chk #(
  .PADDR_W   (PADDR_W),
  .LINE_BYTES(LINE_BYTES),
  .ASN_W     (ASN_W),
  .HIST_W    (HIST_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .flush      (flush),
  .curAsn     (curAsn),
  .lookupValid(lookupValid),
  .lookupAddr (lookupAddr),
  .respValid  (respValid),
  .respHit    (respHit),
  .respData   (respData),
  .respHist   (respHist),
  .fillValid  (fillValid),
  .fillAddr   (fillAddr),
  .fillGlobal (fillGlobal),
  .fillData   (fillData)
);

// File: tb/sim_icache_asn.sv
`timescale 1ns/1ps
module sim_icache_asn;
  localparam int PADDR_W     = 20;
  localparam int CACHE_BYTES = 1024;
  localparam int LINE_BYTES  = 32;
  localparam int ASN_W       = 6;
  localparam int HIST_W      = 8;
  localparam int LINE_BITS   = LINE_BYTES * 8;
  localparam int OFF_W       = $clog2(LINE_BYTES);
  localparam int IDX_W       = $clog2(CACHE_BYTES / LINE_BYTES);
  localparam int TAG_W       = PADDR_W - IDX_W - OFF_W;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 flush = 1'b0;
  logic [ASN_W-1:0]     curAsn = '0;
  logic                 lookupValid = 1'b0;
  logic [PADDR_W-1:0]   lookupAddr = '0;
  logic                 respValid, respHit;
  logic [LINE_BITS-1:0] respData;
  logic [HIST_W-1:0]    respHist;
  logic                 fillValid = 1'b0;
  logic [PADDR_W-1:0]   fillAddr = '0;
  logic                 fillGlobal = 1'b0;
  logic [LINE_BITS-1:0] fillData = '0;
  logic                 histValid = 1'b0;
  logic [PADDR_W-1:0]   histAddr = '0;
  logic [HIST_W-1:0]    histData = '0;

  always #10 clk = ~clk;  // 50 MHz

  icache_asn #(
    .PADDR_W(PADDR_W), .CACHE_BYTES(CACHE_BYTES), .LINE_BYTES(LINE_BYTES),
    .ASN_W(ASN_W), .HIST_W(HIST_W)
  ) u0 (.*);

  typedef struct packed {
    logic                 hit;
    logic [LINE_BITS-1:0] data;
    logic [HIST_W-1:0]    hist;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  function automatic logic [PADDR_W-1:0] mkAddr(int tag, int idx);
    return {tag[TAG_W-1:0], idx[IDX_W-1:0], {OFF_W{1'b0}}};
  endfunction

  function automatic logic [LINE_BITS-1:0] lineData(int seed);
    logic [LINE_BITS-1:0] d;
    for (int k = 0; k < LINE_BITS / 32; k++)
      d[k*32 +: 32] = seed * 32'h01000193 + k * 32'h9E3779B1;
    return d;
  endfunction

  // driver helpers: set fields, then tick
  task automatic setLookup(int tag, int idx, int asn, logic eHit, int seed, int eHist, string req);
    expItem_t e;
    lookupValid = 1'b1;
    lookupAddr  = mkAddr(tag, idx);
    curAsn      = asn[ASN_W-1:0];
    e.hit  = eHit;
    e.data = lineData(seed);
    e.hist = eHist[HIST_W-1:0];
    expQ.push_back(e);
    tagQ.push_back(req);
  endtask

  task automatic setFill(int tag, int idx, int asn, logic glob, int seed);
    fillValid  = 1'b1;
    fillAddr   = mkAddr(tag, idx);
    curAsn     = asn[ASN_W-1:0];
    fillGlobal = glob;
    fillData   = lineData(seed);
  endtask

  task automatic setHist(int tag, int idx, int val);
    histValid = 1'b1;
    histAddr  = mkAddr(tag, idx);
    histData  = val[HIST_W-1:0];
  endtask

  task automatic tick();
    @(negedge clk);
    lookupValid = 1'b0;
    fillValid   = 1'b0;
    histValid   = 1'b0;
    flush       = 1'b0;
  endtask

  task automatic lookup(int tag, int idx, int asn, logic eHit, int seed, int eHist, string req);
    setLookup(tag, idx, asn, eHit, seed, eHist, req);
    tick();
  endtask

  task automatic fill(int tag, int idx, int asn, logic glob, int seed);
    setFill(tag, idx, asn, glob, seed);
    tick();
  endtask

  // monitor: compares each response against the scoreboard head
  always @(negedge clk) begin
    if (rstN && !finished && respValid) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R11 unexpected response act=1 exp=0");
      end else begin
        expItem_t e;
        string    r;
        e = expQ.pop_front();
        r = tagQ.pop_front();
        total++;
        if (respHit !== e.hit) begin
          bad++;
          $display("FAIL %s hit act=%0b exp=%0b", r, respHit, e.hit);
        end else if (e.hit && (respData !== e.data || respHist !== e.hist)) begin
          bad++;
          $display("FAIL %s data/hist act=%h/%h exp=%h/%h", r, respData, respHist, e.data, e.hist);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    total++;
    if (respValid !== 1'b0 || respHit !== 1'b0) begin
      bad++;
      $display("FAIL R11 reset resp act=%0b%0b exp=00", respValid, respHit);
    end

    lookup(1, 3, 5, 0, 0, 0, "R1");              // cold miss
    fill(1, 3, 5, 0, 11);
    lookup(1, 3, 5, 1, 11, 0, "R2");             // hit, hist zero
    lookup(1, 3, 6, 0, 0, 0, "R3");              // ASN mismatch
    lookup(2, 3, 5, 0, 0, 0, "R3");              // tag mismatch

    fill(4, 7, 2, 1, 22);                        // global line
    lookup(4, 7, 9, 1, 22, 0, "R4");
    lookup(4, 7, 2, 1, 22, 0, "R4");

    setHist(1, 3, 8'hA5); tick();
    lookup(1, 3, 5, 1, 11, 8'hA5, "R5");
    setHist(2, 3, 8'h3C); tick();                // not resident
    lookup(1, 3, 5, 1, 11, 8'hA5, "R6");

    fill(2, 3, 5, 0, 33);                        // evict tag 1
    lookup(1, 3, 5, 0, 0, 0, "R7");
    lookup(2, 3, 5, 1, 33, 0, "R7");

    setFill(6, 12, 5, 0, 44);                    // lookup in the fill cycle
    setLookup(6, 12, 5, 0, 0, 0, "R9");
    tick();
    lookup(6, 12, 5, 1, 44, 0, "R9");

    setHist(2, 3, 8'h77); tick();
    setFill(2, 3, 5, 0, 55);                     // fill and hist collide
    setHist(2, 3, 8'hFF);
    tick();
    lookup(2, 3, 5, 1, 55, 0, "R10");

    setFill(9, 20, 5, 0, 66);                    // flush beats fill
    flush = 1'b1;
    tick();
    lookup(9, 20, 5, 0, 0, 0, "R8");
    lookup(2, 3, 5, 0, 0, 0, "R8");
    lookup(4, 7, 2, 0, 0, 0, "R8");
    fill(9, 20, 3, 0, 77);
    lookup(9, 20, 3, 1, 77, 0, "R2");

    repeat (3) @(negedge clk);
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL R11 missing responses act=%0d exp=0", expQ.size());
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule